// File: doc/BRIEF.md
# Host Packet Transmit Assembler

This block sits behind a host command channel and rebuilds outbound link-layer packets from 64-bit command words. Each packet command carries a single packet dword and a flag that says whether more dwords follow or whether this dword closes the packet. Dwords are collected in a local store. Only after the closing dword has arrived is the packet released on a valid/ready/last stream, one dword per beat, so the downstream transmitter never sees a partial packet.

Keep-alive words can appear anywhere between packet dwords, and they are dropped. Commands whose flag byte selects register access are not packet data. They are handed to the register access decoder on a one-cycle valid strobe. Words without the correct marker byte are discarded. If a packet grows past the store size without a closing flag, it is thrown away and an error pulse is raised. The rest of that broken packet is then skipped.

Top module: `tx_pkt_assembler`

## Requirements
- R1: After reset, `out_valid`, `reg_valid` and `ovf_err` are 0 and `cmd_ready` is 1.
- R2: A command is recognised only when bits 63:56 equal 0x77. Any other word is accepted and has no effect on any output or on the packet being built.
- R3: The packet dword is taken from bits 31:0 with byte 0 (bits 7:0) as its most significant byte, i.e. `{w[7:0],w[15:8],w[23:16],w[31:24]}`.
- R4: The flag byte is bits 55:48. A flag of 0x00 appends a dword, and 0x04 appends the final dword. The packet is emitted in arrival order only after its final dword, with `out_last` set on that dword. Lengths 1 to MAX_DW (36) are forwarded unchanged, including 3- and 4-dword headers.
- R5: A flag of 0x02 (keep-alive), or any other flag with bits 4 and 5 clear that is neither 0x00 nor 0x04, is dropped and leaves the packet under construction intact.
- R6: A recognised command whose flag has bit 4 or bit 5 set appears whole on `reg_word`, with `reg_valid` high for exactly one cycle, on the cycle after it is accepted. It never becomes packet data.
- R7: `cmd_ready` is low from the cycle after a final dword is accepted until the last dword of that packet is handed over, and high otherwise.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: A packet dword (0x00 or 0x04) that arrives when MAX_DW dwords are already stored raises `ovf_err` for one cycle, and the stored dwords are discarded without being emitted.
- R10: After an overflow caused by a 0x00 dword, packet dwords are dropped up to and including the next 0x04 dword. After an overflow caused by a 0x04 dword, the next packet dword starts a new packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Host command word present |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_word | input | 64 | Host command word |
| out_valid | output | 1 | Packet dword available |
| out_ready | input | 1 | Downstream takes the dword |
| out_data | output | 32 | Packet dword |
| out_last | output | 1 | Final dword of the packet |
| reg_valid | output | 1 | One-cycle strobe for a register command |
| reg_word | output | 64 | Register command word for the register decoder |
| ovf_err | output | 1 | One-cycle pulse when a packet overflows the store |

## Verification
Two functions can land in the same cycle. In the first case, a final flag and the overflow limit coincide: the bench sends a 37-dword packet whose 37th dword carries the final flag. It then expects an error pulse, no output, and a clean start for the next packet, with no skip phase in between. In the second case, register or keep-alive words are slipped between the dwords of a packet that is being built, or into a skip phase. The bench then judges both the register strobe and the untouched packet content. A behavioural queue model is compared against every output on every clock, with random backpressure on the stream.

// File: rtl/tx_asm_pkg.sv
package tx_asm_pkg;

  localparam logic [7:0] MARK_BYTE   = 8'h77;
  localparam logic [7:0] FLAG_MORE   = 8'h00;
  localparam logic [7:0] FLAG_CLOSE  = 8'h04;

  typedef enum logic [1:0] {
    K_DROP = 2'd0,
    K_REG  = 2'd1,
    K_DATA = 2'd2,
    K_LAST = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SEND = 2'd1,
    ST_SKIP = 2'd2
  } asm_state_e;

endpackage

// File: rtl/tx_cmd_classify.sv
module tx_cmd_classify
  import tx_asm_pkg::*;
(
  input  logic [15:0] hdr_bytes,   // {marker, flag}
  input  logic [31:0] body_bytes,  // bytes 3..0 of the command
  output cmd_kind_e   kind,
  output logic [31:0] dword
);

  logic [7:0] mark;
  logic [7:0] flag;

  assign mark = hdr_bytes[15:8];
  assign flag = hdr_bytes[7:0];

  // byte 0 of the command is the most significant byte of the dword
  assign dword = {body_bytes[7:0], body_bytes[15:8], body_bytes[23:16], body_bytes[31:24]};

  always_comb begin
    kind = K_DROP;
    if (mark == MARK_BYTE) begin
      if (flag[4] || flag[5])        kind = K_REG;
      else if (flag == FLAG_MORE)    kind = K_DATA;
      else if (flag == FLAG_CLOSE)   kind = K_LAST;
      else                           kind = K_DROP;
    end
  end

endmodule

// File: rtl/tx_pkt_store.sv
module tx_pkt_store #(
  parameter int DEPTH = 36,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tx_asm_ctrl.sv
module tx_asm_ctrl
  import tx_asm_pkg::*;
#(
  parameter int MAX_DW = 36,
  localparam int AW    = $clog2(MAX_DW),
  localparam int CW    = $clog2(MAX_DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  cmd_kind_e     kind,
  input  logic          out_ready,
  output logic          cmd_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          out_last,
  output logic          ovf_err
);

  asm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] rd_q, rd_d;
  logic          ovf_q, ovf_d;
  logic          acc;
  logic          is_pkt;

  assign cmd_ready = (state_q != ST_SEND);
  assign acc       = cmd_valid && cmd_ready;
  assign is_pkt    = (kind == K_DATA) || (kind == K_LAST);
  assign out_valid = (state_q == ST_SEND);
  assign out_last  = out_valid && (rd_q == len_q - 1'b1);
  assign wr_addr   = cnt_q[AW-1:0];
  assign rd_addr   = rd_q[AW-1:0];
  assign ovf_err   = ovf_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    rd_d    = rd_q;
    ovf_d   = 1'b0;
    wr_en   = 1'b0;
    case (state_q)
      ST_FILL: begin
        if (acc && is_pkt) begin
          if (cnt_q == CW'(MAX_DW)) begin
            ovf_d = 1'b1;
            cnt_d = '0;
            if (kind == K_DATA) state_d = ST_SKIP;
          end else begin
            wr_en = 1'b1;
            if (kind == K_LAST) begin
              len_d   = cnt_q + 1'b1;
              cnt_d   = '0;
              rd_d    = '0;
              state_d = ST_SEND;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
      end
      ST_SKIP: begin
        if (acc && kind == K_LAST) state_d = ST_FILL;
      end
      ST_SEND: begin
        if (out_ready) begin
          if (out_last) state_d = ST_FILL;
          else          rd_d    = rd_q + 1'b1;
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
      len_q   <= '0;
      rd_q    <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      rd_q    <= rd_d;
      ovf_q   <= ovf_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_DW)); // R9

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R9

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CW'(MAX_DW))); // R4

  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && cmd_ready)); // R7

endmodule

// File: rtl/tx_pkt_assembler.sv
module tx_pkt_assembler
  import tx_asm_pkg::*;
#(
  parameter int MAX_DW = 36,
  parameter int CMD_W  = 64,
  localparam int DW    = 32,
  localparam int AW    = $clog2(MAX_DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             reg_valid,
  output logic [CMD_W-1:0] reg_word,
  output logic             ovf_err
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  cmd_kind_e        kind;
  logic [DW-1:0]    dword;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_addr;
  logic             acc;
  logic             reg_hit;
  logic             reg_valid_q;
  logic [CMD_W-1:0] reg_word_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tx_cmd_classify u_classify (
    .hdr_bytes  (cmd_word[63:48]),
    .body_bytes (cmd_word[31:0]),
    .kind       (kind),
    .dword      (dword)
  );

  tx_asm_ctrl #(.MAX_DW(MAX_DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .kind      (kind),
    .out_ready (out_ready),
    .cmd_ready (cmd_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_last  (out_last),
    .ovf_err   (ovf_err)
  );

  tx_pkt_store #(.DEPTH(MAX_DW), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (dword),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  assign acc     = cmd_valid && cmd_ready;
  assign reg_hit = acc && (kind == K_REG);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      reg_valid_q <= 1'b0;
      reg_word_q  <= '0;
    end else begin
      reg_valid_q <= reg_hit;
      if (reg_hit) reg_word_q <= cmd_word;
    end
  end

  assign reg_valid = reg_valid_q;
  assign reg_word  = reg_word_q;

  AST_REG_ECHO: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_hit |=> (reg_valid && reg_word == $past(cmd_word))); // R6

  AST_NO_STRAY_REG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc && kind != K_REG) |=> !reg_valid); // R5

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8

endmodule

// File: tb/tb_tx_pkt_assembler.sv
module tb_tx_pkt_assembler;

  localparam int MAX_DW = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;
  logic        reg_valid;
  logic [63:0] reg_word;
  logic        ovf_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string scen = "R1";

  // model state
  bit          m_send = 0;
  bit          m_skip = 0;
  bit          m_regv = 0;
  bit          m_ovf  = 0;
  logic [63:0] m_regw = '0;
  bit          m_acc  = 0;
  logic [31:0] m_build[$];
  logic [31:0] m_out[$];

  bit          nxt_valid = 0;
  logic [63:0] nxt_word = '0;
  bit          rdy_rand = 0;

  always #2 clk = ~clk;

  tx_pkt_assembler #(.MAX_DW(MAX_DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .reg_valid(reg_valid),
    .reg_word(reg_word), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s actual=%h expected=%h t=%0t", tag, scen, what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] dw, input logic [7:0] flag);
    return {8'h77, flag, 16'h0, dw[7:0], dw[15:8], dw[23:16], dw[31:24]};
  endfunction

  task automatic cyc();
    logic [31:0] dw;
    logic [7:0]  fl;
    bit nr, no;
    @(negedge clk);
    cmd_valid = nxt_valid;
    cmd_word  = nxt_word;
    out_ready = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
    #1;
    chk(cmd_ready == !m_send, "R7", "cmd_ready", 64'(cmd_ready), 64'(!m_send));
    chk(out_valid == m_send, "R4", "out_valid", 64'(out_valid), 64'(m_send));
    if (m_send) begin
      chk(out_data == m_out[0], "R3", "out_data", 64'(out_data), 64'(m_out[0]));
      chk(out_last == (m_out.size() == 1), "R4", "out_last", 64'(out_last), 64'(m_out.size() == 1));
    end
    chk(reg_valid == m_regv, "R6", "reg_valid", 64'(reg_valid), 64'(m_regv));
    if (m_regv) chk(reg_word == m_regw, "R6", "reg_word", reg_word, m_regw);
    chk(ovf_err == m_ovf, "R9", "ovf_err", 64'(ovf_err), 64'(m_ovf));
    // model step for the coming edge
    m_acc = cmd_valid && !m_send;
    nr = 0; no = 0;
    if (m_send) begin
      if (out_ready) begin
        void'(m_out.pop_front());
        if (m_out.size() == 0) m_send = 0;
      end
    end else if (cmd_valid && cmd_word[63:56] == 8'h77) begin
      fl = cmd_word[55:48];
      dw = {cmd_word[7:0], cmd_word[15:8], cmd_word[23:16], cmd_word[31:24]};
      if (fl[4] || fl[5]) begin
        nr = 1; m_regw = cmd_word;
      end else if (fl == 8'h00 || fl == 8'h04) begin
        if (m_skip) begin
          if (fl == 8'h04) m_skip = 0;
        end else if (m_build.size() == MAX_DW) begin
          no = 1;
          m_build.delete();
          if (fl == 8'h00) m_skip = 1;
        end else begin
          m_build.push_back(dw);
          if (fl == 8'h04) begin
            m_out = m_build;
            m_build.delete();
            m_send = 1;
          end
        end
      end
    end
    m_regv = nr;
    m_ovf  = no;
    cycles++;
  endtask

  task automatic send(input logic [63:0] w);
    nxt_valid = 1; nxt_word = w;
    do cyc(); while (!m_acc);
    nxt_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic pkt(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) send(mk(base + 32'(i) * 32'h01010101, (i == n - 1) ? 8'h04 : 8'h00));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values, through the synchroniser
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    scen = "R4 three-dword header";
    pkt(3, 32'h4A000001); idle(6);
    scen = "R4 four-dword header";
    pkt(4, 32'h20000048); idle(6);
    scen = "R4 single dword";
    pkt(1, 32'hDEADBEEF); idle(4);
    scen = "R4 full 36-dword packet";
    pkt(MAX_DW, 32'h00112233); idle(40);

    scen = "R8 backpressure";
    rdy_rand = 1;
    pkt(7, 32'hA5A5A5A5); idle(30);
    pkt(MAX_DW, 32'h0F0F0F0F); idle(100);
    rdy_rand = 0;

    scen = "R5 keep-alive and odd flag mid-packet";
    send(mk(32'h11111111, 8'h00));
    send(mk(32'hFFEEDDCC, 8'h02));
    send(mk(32'h22222222, 8'h00));
    send(mk(32'h33333333, 8'h01));
    send(mk(32'h44444444, 8'h04)); idle(6);

    scen = "R6 register words mid-packet";
    send(mk(32'h55555555, 8'h00));
    send(mk(32'h00000008, 8'h13));
    send(mk(32'h66666666, 8'h00));
    send(mk(32'h00000016, 8'h23));
    send(mk(32'h00000004, 8'h31));
    send(mk(32'h77777777, 8'h04));
    scen = "R7 register word waits while sending";
    send(mk(32'h0000000A, 8'h11)); idle(4);

    scen = "R2 bad marker ignored";
    send(mk(32'h88888888, 8'h00));
    send({8'h76, 8'h04, 16'h0, 32'h99999999});
    send({8'h00, 8'h13, 16'h0, 32'h12345678});
    send(mk(32'hAAAAAAAA, 8'h04)); idle(5);

    scen = "R9 R10 final dword overflows";
    pkt(MAX_DW + 1, 32'h01000000); idle(3);
    pkt(2, 32'hC0C0C0C0); idle(4);

    scen = "R9 R10 overflow then skip to final";
    for (int i = 0; i < MAX_DW + 4; i++) send(mk(32'h03000000 + 32'(i), 8'h00));
    send(mk(32'hFFEEDDCC, 8'h02));
    send(mk(32'h0000000C, 8'h21));
    send(mk(32'h0BADF00D, 8'h04)); idle(3);
    pkt(3, 32'h0E0E0E0E); idle(5);

    scen = "R8 mixed random tail";
    rdy_rand = 1;
    for (int k = 0; k < 20; k++) begin
      pkt(int'($urandom_range(1, MAX_DW)), $urandom);
      if (k % 3 == 0) send(mk(32'hFFEEDDCC, 8'h02));
      if (k % 4 == 1) send(mk($urandom, 8'h12));
    end
    idle(100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule